// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer for 9-bit words. The write side and the read side each have their own clock. The two clocks can run at unrelated rates, or the same clock can drive both. A word is stored on a write-clock edge when the write enables allow it, and it is presented on the output register on a read-clock edge when both read enables are asserted. The data output is a tri-state bus, and it floats while the output enable is high.

Four active-low flags report the fill state: empty, full, almost-empty and almost-full. The empty-side flags are registered on the read clock and the full-side flags on the write clock. Each side sees the opposite pointer through a Gray-coded two-flop synchronizer. A flag can therefore report a state the FIFO has already left, but never one it has not yet reached.

The almost thresholds sit in an offset register that resets to 7 for both fields. The dual-purpose pin `wen_b_ld` is sampled while reset is held. If it is high during reset, it acts as a second write enable. If it is low during reset, it becomes the load control. Holding it low together with a write or read request then writes the offset register from `din`, or returns the register contents on `dout`, one 9-bit access at a time.

Top module: `pflag_fifo`

## Requirements
- R1: Words leave the FIFO in the order they were accepted, with all 9 bits intact. A word popped on a read-clock edge is visible on `dout` after that edge.
- R2: A write attempted while `full_n` is low does not store a word and does not displace stored data.
- R3: A read attempted while `empty_n` is low pops nothing and leaves `dout` unchanged.
- R4: `wen_a_n` (active low) must be low for a data write. If `wen_b_ld` was high during reset, it must also be high; while it is low, nothing is written. If `wen_b_ld` was low during reset, `wen_a_n` with `wen_b_ld` high writes data.
- R5: A read needs both `ren_a_n` and `ren_b_n` low. With only one of them low, nothing is popped and `dout` does not change.
- R6: When the FIFO is idle, `empty_n` is low exactly when it holds 0 words, and `aempty_n` is low exactly when it holds no more words than the almost-empty offset.
- R7: When the FIFO is idle, `full_n` is low exactly when it holds DEPTH words, and `afull_n` is low exactly when its free space is no more than the almost-full offset. The occupancy never exceeds DEPTH.
- R8: After reset, both offsets are 7. With DEPTH 16, `aempty_n` is low at 7 words and high at 8, and `afull_n` is low at 9 words and high at 8.
- R9: In load mode, a write-clock edge with `wen_a_n` low and `wen_b_ld` low stores `din` into the offset register, not into the FIFO. The accesses go to the almost-empty field first, then the almost-full field. Each field takes ceil(log2(DEPTH)/9) accesses, low 9 bits first, so one access per field at DEPTH 16. After the last field the sequence returns to the first field, and reset clears it.
- R10: In load mode, a read-clock edge with both read enables low and `wen_b_ld` low places the current offset access on `dout`, zero-extended to 9 bits. It pops no data, and it follows the same field order and wrap as R9 on its own sequence counter.
- R11: While `oe_n` is high, `dout` is high impedance.
- R12: Reset empties the FIFO. It drives `empty_n` and `aempty_n` low, drives `full_n` and `afull_n` high, and clears the output register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low; `wen_b_ld` is sampled while it is low |
| din | input | 9 | Write data, or offset data in load mode |
| wen_a_n | input | 1 | Primary write enable, active low |
| wen_b_ld | input | 1 | Second write enable (active high), or offset load control (active low) in load mode |
| ren_a_n | input | 1 | Read enable, active low |
| ren_b_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data or offset readback, tri-stated while `oe_n` is high |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read-clock domain |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write-clock domain |

## Verification
A write and a read can land close together on the two unrelated clocks, 10 ns and 13 ns, while the FIFO sits at empty or full. In that case, one side acts on a flag that is stale with respect to the other side's move. The randomized phase creates this overlap by filling hard and then draining hard, with random enables on both sides. Every accepted write and every pop is judged against a queue model: a pop from an empty model or a push into a full model is a failure, and so is any data mismatch. Exact flag values are checked only after both clocks have idled long enough for the synchronizers to settle.

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int DEPTH  = 16,
  parameter int DW     = 9,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen_a_n,
  input  logic          wen_b_ld,
  input  logic          ren_a_n,
  input  logic          ren_b_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PARTS = (AW + DW - 1) / DW;
  localparam int PW    = PARTS * DW;
  localparam int NACC  = 2 * PARTS;
  localparam int SW    = (NACC > 1) ? $clog2(NACC) : 1;
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic          ld_mode;
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   wq1, wq2, rq1, rq2;
  logic [AW:0]   wbin_nx, rbin_nx, wsync_bin, rsync_bin, used_w, used_r;
  logic [2*PW-1:0] offs;
  logic [SW-1:0] wseq, rseq;
  logic [DW-1:0] q, off_part;
  logic [AW-1:0] ae_off, af_off;

  wire wr_data = !wen_a_n && wen_b_ld && full_n;
  wire wr_off  = ld_mode && !wen_a_n && !wen_b_ld;
  wire rd_req  = !ren_a_n && !ren_b_n;
  wire rd_data = rd_req && empty_n && (!ld_mode || wen_b_ld);
  wire rd_off  = rd_req && ld_mode && !wen_b_ld;

  assign ae_off    = offs[AW-1:0];
  assign af_off    = offs[PW +: AW];
  assign wbin_nx   = wbin + {{AW{1'b0}}, wr_data};
  assign rbin_nx   = rbin + {{AW{1'b0}}, rd_data};
  assign rsync_bin = g2b(rq2);
  assign wsync_bin = g2b(wq2);
  assign used_w    = wbin_nx - rsync_bin;
  assign used_r    = wsync_bin - rbin_nx;
  assign dout      = oe_n ? 'z : q;

  always_comb begin
    off_part = '0;
    for (int k = 0; k < NACC; k++)
      if (rseq == SW'(k)) off_part = offs[k*DW +: DW];
  end

  always_ff @(posedge wr_clk)
    if (!rst_n) ld_mode <= !wen_b_ld;

  always_ff @(posedge wr_clk)
    if (wr_data) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rq1     <= '0;
      rq2     <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      wseq    <= '0;
      offs    <= {PW'(AF_DEF), PW'(AE_DEF)};
    end else begin
      rq1     <= rgray;
      rq2     <= rq1;
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      full_n  <= used_w != FULLV;
      afull_n <= (FULLV - used_w) > {1'b0, af_off};
      if (wr_off) begin
        for (int k = 0; k < NACC; k++)
          if (wseq == SW'(k)) offs[k*DW +: DW] <= din;
        wseq <= (wseq == SW'(NACC-1)) ? '0 : wseq + 1'b1;
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wq1      <= '0;
      wq2      <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      rseq     <= '0;
      q        <= '0;
    end else begin
      wq1      <= wgray;
      wq2      <= wq1;
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      empty_n  <= wsync_bin != rbin_nx;
      aempty_n <= used_r > {1'b0, ae_off};
      if (rd_data) q <= mem[rbin[AW-1:0]];
      else if (rd_off) begin
        q    <= off_part;
        rseq <= (rseq == SW'(NACC-1)) ? '0 : rseq + 1'b1;
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));
  assert_no_underflow_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));
  assert_full_has_afull_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  assert_occupancy_bound_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wbin - rsync_bin) <= FULLV);
  assert_empty_has_aempty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  assert_readback_no_pop_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_off |=> $stable(rbin));
endmodule

// File: tb/pflag_fifo_bench.sv
`timescale 1ns/100ps
module pflag_fifo_bench;
  localparam int DEPTH = 16;
  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [8:0] din = '0;
  logic wen_a_n = 1, wen_b_ld = 1, ren_a_n = 1, ren_b_n = 1, oe_n = 0;
  tri1 [8:0] dout_w;
  logic empty_n, aempty_n, full_n, afull_n;
  int checks = 0, errors = 0;
  logic [8:0] model[$];
  int ae_o = 7, af_o = 7;
  logic [8:0] last_out = '0;

  always #5   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  pflag_fifo u_pflag_fifo (.wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wen_a_n(wen_a_n), .wen_b_ld(wen_b_ld), .ren_a_n(ren_a_n), .ren_b_n(ren_b_n),
    .oe_n(oe_n), .dout(dout_w), .empty_n(empty_n), .aempty_n(aempty_n),
    .full_n(full_n), .afull_n(afull_n));

  function automatic logic exp_aempty_n(int n, int off); return n > off; endfunction
  function automatic logic exp_afull_n(int n, int off); return (DEPTH - n) > off; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic reset_dut(input logic ld);
    rst_n = 0; wen_b_ld = !ld; wen_a_n = 1; ren_a_n = 1; ren_b_n = 1;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk); rst_n = 1; wen_b_ld = 1;
    model.delete(); ae_o = 7; af_o = 7; last_out = '0;
  endtask

  task automatic settle();
    repeat (5) @(posedge rd_clk);
    repeat (5) @(posedge wr_clk);
    @(negedge wr_clk);
  endtask

  task automatic chk_flags(input string tag);
    int n = model.size();
    settle();
    chk(empty_n == (n != 0), {tag, " R6 empty_n"}, empty_n, n != 0);
    chk(aempty_n == exp_aempty_n(n, ae_o), {tag, " R6 aempty_n"}, aempty_n, exp_aempty_n(n, ae_o));
    chk(full_n == (n != DEPTH), {tag, " R7 full_n"}, full_n, n != DEPTH);
    chk(afull_n == exp_afull_n(n, af_o), {tag, " R7 afull_n"}, afull_n, exp_afull_n(n, af_o));
  endtask

  task automatic wr_word(input logic [8:0] d, input logic b = 1);
    logic ok;
    @(negedge wr_clk); ok = full_n; din = d; wen_a_n = 0; wen_b_ld = b;
    @(negedge wr_clk); wen_a_n = 1; wen_b_ld = 1;
    if (ok && b) begin
      if (model.size() >= DEPTH) chk(0, "R2 write accepted while full", model.size(), DEPTH);
      else model.push_back(d);
    end
  endtask

  task automatic rd_word(input logic a = 0, input logic b = 0);
    logic ok; logic [8:0] e;
    @(negedge rd_clk); ok = empty_n; ren_a_n = a; ren_b_n = b;
    @(negedge rd_clk); ren_a_n = 1; ren_b_n = 1;
    if (ok && !a && !b) begin
      if (model.size() == 0) chk(0, "R3 pop while empty", 1, 0);
      else begin
        e = model.pop_front();
        chk(dout_w == e, "R1 read order", dout_w, e);
        last_out = e;
      end
    end else chk(dout_w == last_out, "R3/R5 output held", dout_w, last_out);
  endtask

  task automatic off_write(input logic [8:0] d);
    @(negedge wr_clk); din = d; wen_a_n = 0; wen_b_ld = 0;
    @(negedge wr_clk); wen_a_n = 1; wen_b_ld = 1;
  endtask

  task automatic off_read(input logic [8:0] e);
    @(negedge rd_clk); wen_b_ld = 0; ren_a_n = 0; ren_b_n = 0;
    @(negedge rd_clk); ren_a_n = 1; ren_b_n = 1; wen_b_ld = 1;
    chk(dout_w == e, "R10 offset readback", dout_w, e);
    last_out = e;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog expired act 0 exp 1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    reset_dut(0);
    @(negedge rd_clk);
    chk(dout_w == 9'h000, "R12 reset dout", dout_w, 0);
    chk(!empty_n && !aempty_n && full_n && afull_n, "R12 reset flags",
        {empty_n, aempty_n, full_n, afull_n}, 4'b0011);

    for (int i = 0; i < 3; i++) wr_word(9'h0F0 + 9'(i), 0);
    chk_flags("R4 second enable low blocks");

    for (int i = 0; i < 7; i++) wr_word(9'h100 + 9'(i));
    chk_flags("R8 seven words");
    wr_word(9'h107);
    chk_flags("R8 eight words");
    rd_word(0, 1);
    rd_word(1, 0);
    chk_flags("R5 single enable no pop");
    wr_word(9'h108);
    chk_flags("R8 nine words");
    for (int i = 9; i < DEPTH; i++) wr_word(9'h100 + 9'(i));
    chk_flags("R7 full");
    for (int i = 0; i < 3; i++) wr_word(9'h1EE);
    chk_flags("R2 after writes while full");
    for (int i = 0; i < DEPTH; i++) rd_word();
    chk_flags("R6 drained");
    rd_word(); rd_word();
    chk_flags("R3 after reads while empty");

    wr_word(9'h055);
    settle();
    @(negedge wr_clk); oe_n = 1; #1;
    chk(dout_w == 9'h1FF, "R11 high impedance reads pulled value", dout_w, 9'h1FF);
    oe_n = 0;
    rd_word();

    fork
      begin
        for (int i = 0; i < 600; i++) begin
          logic ok, en, b; logic [8:0] d;
          @(negedge wr_clk);
          ok = full_n; en = ($urandom % 100) < ((i < 300) ? 85 : 25);
          b = ($urandom % 10) != 0; d = 9'($urandom);
          din = d; wen_a_n = !en; wen_b_ld = b;
          if (en && b && ok) begin
            if (model.size() >= DEPTH) chk(0, "R2 random write while full", model.size(), DEPTH);
            else model.push_back(d);
          end
        end
        @(negedge wr_clk); wen_a_n = 1; wen_b_ld = 1;
      end
      begin
        logic pend = 0; logic [8:0] e = '0;
        for (int i = 0; i < 560; i++) begin
          logic ok, a, b;
          @(negedge rd_clk);
          if (pend) begin chk(dout_w == e, "R1 random order", dout_w, e); last_out = e; end
          else chk(dout_w == last_out, "R3/R5 random hold", dout_w, last_out);
          ok = empty_n; a = ($urandom % 100) < ((i < 230) ? 30 : 90);
          b = ($urandom % 100) < ((i < 230) ? 30 : 90);
          ren_a_n = !a; ren_b_n = !b; pend = 0;
          if (ok && a && b) begin
            if (model.size() == 0) chk(0, "R3 random pop while empty", 1, 0);
            else begin e = model.pop_front(); pend = 1; end
          end
        end
        @(negedge rd_clk);
        if (pend) begin chk(dout_w == e, "R1 random order", dout_w, e); last_out = e; end
        ren_a_n = 1; ren_b_n = 1;
      end
    join
    while (model.size() != 0) rd_word();
    chk_flags("R6 random drained");

    reset_dut(1);
    chk_flags("R8 load mode defaults");
    off_write(9'd3); off_write(9'd2);
    ae_o = 3; af_o = 2;
    wr_word(9'h1A5);
    settle();
    off_read(9'd3); off_read(9'd2); off_read(9'd3);
    chk_flags("R9 new offsets one word");
    rd_word();
    for (int i = 0; i < 3; i++) wr_word(9'h0A0 + 9'(i));
    chk_flags("R9 three words");
    wr_word(9'h0A3);
    chk_flags("R9 four words");
    for (int i = 4; i < 13; i++) wr_word(9'h0A0 + 9'(i));
    chk_flags("R9 thirteen words");
    wr_word(9'h0AD);
    chk_flags("R9 fourteen words");
    while (model.size() != 0) rd_word();
    chk_flags("R4 load mode drained");
    finish_run();
  end
endmodule